// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings one DDR SDRAM device from power-on into a usable state. When reset is released it keeps the clock-enable pin low and counts a stable-clock interval of 200 µs. The length of that interval in cycles comes from a clock-frequency parameter. It then raises clock enable with a NOP. After that it drives a fixed series of commands on the chip-select, row-strobe, column-strobe and write-enable pins, together with matching bank-address and address values. The series is: precharge of all banks, extended mode register write (DLL on), mode register write with DLL reset, a second precharge of all banks, several auto-refresh commands, and a final mode register write.

Burst length, burst type and CAS latency are fixed when the block is built, through parameters. Command spacing is also set by parameters, given in clock cycles. The block holds back its completion flag until the gap after the last command has run out and the DLL lock window after the DLL reset has closed. After that it drives NOP for good. A memory controller waits on `init_done` before it sends any traffic.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset release until the clock-enable rise, `cke` is 0, every command is NOP and `init_done` is 0. The reset state shows `cke`=0, NOP and `init_done`=0.
- R2: `cke` rises at the (CLK_MHZ*200+1)-th rising clock edge after reset release, with a NOP. It stays high after that. The first precharge follows on the next edge.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n} as NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001 and MODE REGISTER SET=0000.
- R4: Each precharge uses BA=00 and A10=1 with all other address bits 0. The next command follows exactly T_RP cycles later.
- R5: The extended mode register write uses BA=01 and A=0 (A0=0 turns the DLL on). Each mode or extended mode write is followed by its next command exactly T_MRD cycles later (T_MRD ≥ 2).
- R6: The DLL-reset mode write uses BA=00, sets A8=1, and carries the mode word in its other bits.
- R7: Mode word: A2..A0 hold the burst length (2→001, 4→010, 8→011), A3 holds the burst type (0 sequential, 1 interleave), A6..A4 hold the CAS latency (2→010, 2.5→110), and A7 and A12..A9 are 0. Burst lengths or latencies outside these values stop elaboration.
- R8: After the second precharge, max(N_REF,2) auto-refresh commands go out with BA=00 and A=0, each spaced T_RFC cycles from the next command.
- R9: The final mode write uses BA=00 and the same mode word, with A8=0.
- R10: `init_done` rises at edge max(F+T_MRD, D+DLL_LOCK), where F is the edge of the final mode write and D is the edge of the DLL-reset write. It then stays high while `cke` stays high and NOP is driven.
- R11: Exactly 5+max(N_REF,2) non-NOP commands are issued. Every cycle between them carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; selects the mode register target |
| addr | output | 13 | Address bus; carries A10 for precharge and the mode words |
| init_done | output | 1 | High once initialization is complete |

## Verification
Every phase of this sequencer ends with a command on the pins. A wrong step or a miscounted gap therefore moves a command away from its expected edge, or changes its bank or address bits, and it shows up at the very next command the device would see. A broken DLL-lock counter does not show until the completion flag, which rises early or late against the later of the two limits. The checks therefore compare every command's edge, code, bank and address against a timeline computed from the parameters. They run this over configurations where the lock window or the final gap decides the completion edge, and where the refresh count is forced up to two.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int CLK_MHZ          = 200,
  parameter int T_RP             = 3,
  parameter int T_RFC            = 10,
  parameter int T_MRD            = 2,
  parameter int N_REF            = 2,
  parameter int DLL_LOCK         = 200,
  parameter int BURST_LEN        = 4,
  parameter bit BURST_INTERLEAVE = 1'b0,
  parameter int CAS_X2           = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr,
  output logic        init_done
);

  localparam int STABLE = CLK_MHZ * 200;
  localparam int NREF   = (N_REF < 2) ? 2 : N_REF;
  localparam int CW     = $clog2(STABLE + DLL_LOCK + T_RFC + T_RP + T_MRD + 2);
  localparam int RW     = $clog2(NREF + 1);

  localparam logic [2:0] BL_CODE = (BURST_LEN == 2) ? 3'b001 :
                                   (BURST_LEN == 4) ? 3'b010 :
                                   (BURST_LEN == 8) ? 3'b011 : 3'b000;
  localparam logic [2:0] CL_CODE = (CAS_X2 == 4) ? 3'b010 :
                                   (CAS_X2 == 5) ? 3'b110 : 3'b000;
  localparam logic [12:0] MODE_WORD = {6'b0, CL_CODE, BURST_INTERLEAVE, BL_CODE};
  localparam logic [12:0] DLL_RST   = 13'h0100;
  localparam logic [12:0] ALL_BANKS = 13'h0400;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  if (BL_CODE == 3'b000 || CL_CODE == 3'b000 || T_MRD < 2 || T_RP < 1 ||
      T_RFC < 1 || DLL_LOCK < 1 || CLK_MHZ < 1) begin : g_bad_cfg
    $error("ddr_init_seq: unsupported burst length, CAS latency or timing parameter");
  end

  typedef enum logic [3:0] {
    ST_WAIT, ST_CKE, ST_PRE1, ST_EMRS, ST_MRSD, ST_PRE2, ST_REF, ST_MRS, ST_FIN, ST_DONE
  } step_t;

  step_t           state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lock;
  logic [RW-1:0]   refs;
  logic [3:0]      cmd_q;

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT;
      cnt       <= CW'(STABLE - 1);
      lock      <= '0;
      refs      <= '0;
      cke       <= 1'b0;
      cmd_q     <= C_NOP;
      ba        <= 2'b00;
      addr      <= '0;
      init_done <= 1'b0;
    end else begin
      cmd_q <= C_NOP;
      ba    <= 2'b00;
      addr  <= '0;
      if (lock != '0) lock <= lock - 1'b1;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (state)
          ST_WAIT: state <= ST_CKE;
          ST_CKE: begin
            cke   <= 1'b1;
            state <= ST_PRE1;
          end
          ST_PRE1, ST_PRE2: begin
            cmd_q <= C_PRE;
            addr  <= ALL_BANKS;
            cnt   <= CW'(T_RP - 1);
            refs  <= RW'(NREF - 1);
            state <= (state == ST_PRE1) ? ST_EMRS : ST_REF;
          end
          ST_EMRS: begin
            cmd_q <= C_MRS;
            ba    <= 2'b01;
            cnt   <= CW'(T_MRD - 1);
            state <= ST_MRSD;
          end
          ST_MRSD: begin
            cmd_q <= C_MRS;
            addr  <= MODE_WORD | DLL_RST;
            cnt   <= CW'(T_MRD - 1);
            lock  <= CW'(DLL_LOCK - 1);
            state <= ST_PRE2;
          end
          ST_REF: begin
            cmd_q <= C_REF;
            cnt   <= CW'(T_RFC - 1);
            if (refs == '0) state <= ST_MRS;
            else            refs  <= refs - 1'b1;
          end
          ST_MRS: begin
            cmd_q <= C_MRS;
            addr  <= MODE_WORD;
            cnt   <= CW'(T_MRD - 1);
            state <= ST_FIN;
          end
          ST_FIN: begin
            if (lock == '0) begin
              init_done <= 1'b1;
              state     <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd_q == C_NOP && !init_done)); // R1
  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke); // R2
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_PRE) |-> (addr[10] && ba == 2'b00)); // R4
  AST_MRS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_MRS) |=> (cmd_q == C_NOP)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cke && cmd_q == C_NOP)); // R10

endmodule

// File: tb/ddr_init_seq_tb.sv
`timescale 1ns/1ps
module ddr_init_seq_chk #(
  parameter int    CLK_MHZ  = 1,
  parameter int    T_RP     = 3,
  parameter int    T_RFC    = 10,
  parameter int    T_MRD    = 2,
  parameter int    N_REF    = 2,
  parameter int    DLL_LOCK = 200,
  parameter int    BL       = 4,
  parameter bit    BT       = 1'b0,
  parameter int    CAS_X2   = 5,
  parameter string TAG      = "A"
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   fails,
  output logic finished
);
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [12:0] addr;

  ddr_init_seq #(.CLK_MHZ(CLK_MHZ), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
    .N_REF(N_REF), .DLL_LOCK(DLL_LOCK), .BURST_LEN(BL), .BURST_INTERLEAVE(BT),
    .CAS_X2(CAS_X2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done));

  localparam int S       = CLK_MHZ * 200;
  localparam int NR      = (N_REF < 2) ? 2 : N_REF;
  localparam int T_PRE1  = S + 2;
  localparam int T_EMRS  = T_PRE1 + T_RP;
  localparam int T_DLL   = T_EMRS + T_MRD;
  localparam int T_PRE2  = T_DLL + T_MRD;
  localparam int T_REF0  = T_PRE2 + T_RP;
  localparam int T_MRSF  = T_REF0 + NR * T_RFC;
  localparam int T_DONE  = (T_MRSF + T_MRD > T_DLL + DLL_LOCK) ? T_MRSF + T_MRD : T_DLL + DLL_LOCK;
  localparam int BL_C    = (BL == 2) ? 1 : (BL == 4) ? 2 : 3;
  localparam int CL_C    = (CAS_X2 == 5) ? 6 : 2;
  localparam int MW      = CL_C * 16 + int'(BT) * 8 + BL_C;
  localparam int NEV     = 5 + NR;

  int ev_t[16];
  int ev_c[16];
  int ev_b[16];
  int ev_a[16];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL cfg %s %s act=%0d exp=%0d", TAG, req, act, exp);
    end
  endtask

  initial begin
    int c, nev, cke_rise, done_rise, low_bad, post_bad;
    checks = 0; fails = 0; finished = 1'b0;
    nev = 0; cke_rise = -1; done_rise = -1; low_bad = 0; post_bad = 0;
    @(posedge rst_n);
    #1;
    chk(!cke && !init_done && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 reset state",
        {cke, init_done, cs_n, ras_n, cas_n, we_n}, 6'b000111);
    c = 0;
    while (c < T_DONE + 20) begin
      @(negedge clk);
      c++;
      if (!cke && {cs_n, ras_n, cas_n, we_n} != 4'b0111) low_bad++;
      if (cke && cke_rise < 0) cke_rise = c;
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
        if (nev < 16) begin
          ev_t[nev] = c; ev_c[nev] = int'({cs_n, ras_n, cas_n, we_n});
          ev_b[nev] = int'(ba); ev_a[nev] = int'(addr);
        end
        nev++;
      end
      if (init_done && done_rise < 0) done_rise = c;
      if (done_rise >= 0 && (!init_done || !cke || {cs_n, ras_n, cas_n, we_n} != 4'b0111))
        post_bad++;
    end
    chk(low_bad == 0, "R1 NOP while cke low", low_bad, 0);
    chk(cke_rise == S + 1, "R2 cke rise edge", cke_rise, S + 1);
    chk(nev == NEV, "R11 command count", nev, NEV);
    if (nev >= NEV) begin
      for (int i = 0; i < NEV; i++) begin
        int et, ec, ea, eb;
        string rq;
        eb = 0; ea = 0;
        if (i == 0 || i == 3) begin
          et = (i == 0) ? T_PRE1 : T_PRE2; ec = 2; ea = 1024; rq = "R4 precharge";
        end else if (i == 1) begin
          et = T_EMRS; ec = 0; eb = 1; rq = "R5 ext mode write";
        end else if (i == 2) begin
          et = T_DLL; ec = 0; ea = MW + 256; rq = "R6 dll reset write";
        end else if (i == NEV - 1) begin
          et = T_MRSF; ec = 0; ea = MW; rq = "R9 final mode write";
        end else begin
          et = T_REF0 + (i - 4) * T_RFC; ec = 1; rq = "R8 refresh";
        end
        chk(ev_t[i] == et, {rq, " edge"}, ev_t[i], et);
        chk(ev_c[i] == ec, "R3 command code", ev_c[i], ec);
        chk(ev_b[i] == eb, {rq, " bank"}, ev_b[i], eb);
        chk(ev_a[i] == ea, {rq, " address"}, ev_a[i], ea);
      end
      chk((ev_a[2] & 7) == BL_C, "R7 burst length field", ev_a[2] & 7, BL_C);
      chk(((ev_a[2] >> 3) & 1) == int'(BT), "R7 burst type field", (ev_a[2] >> 3) & 1, int'(BT));
      chk(((ev_a[2] >> 4) & 7) == CL_C, "R7 latency field", (ev_a[2] >> 4) & 7, CL_C);
    end
    chk(done_rise == T_DONE, "R10 done edge", done_rise, T_DONE);
    chk(post_bad == 0, "R10 done sticky and quiet", post_bad, 0);
    finished = 1'b1;
  end
endmodule

module ddr_init_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int ca, fa, cb, fb, cc, fc;
  logic da, db, dc;

  always #10 clk = ~clk;

  ddr_init_seq_chk #(.CLK_MHZ(2), .T_RP(3), .T_RFC(10), .T_MRD(2), .N_REF(2),
    .BL(4), .BT(1'b0), .CAS_X2(5), .TAG("lock-bound")) u_cfg_a (
    .clk(clk), .rst_n(rst_n), .checks(ca), .fails(fa), .finished(da));
  ddr_init_seq_chk #(.CLK_MHZ(1), .T_RP(2), .T_RFC(7), .T_MRD(3), .N_REF(1),
    .BL(8), .BT(1'b1), .CAS_X2(4), .TAG("ref-floor")) u_cfg_b (
    .clk(clk), .rst_n(rst_n), .checks(cb), .fails(fb), .finished(db));
  ddr_init_seq_chk #(.CLK_MHZ(1), .T_RP(4), .T_RFC(90), .T_MRD(2), .N_REF(3),
    .BL(2), .BT(1'b0), .CAS_X2(5), .TAG("gap-bound")) u_cfg_c (
    .clk(clk), .rst_n(rst_n), .checks(cc), .fails(fc), .finished(dc));

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cyc, tc, tf;
    cyc = 0;
    while (!(da === 1'b1 && db === 1'b1 && dc === 1'b1) && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    #1;
    tc = ca + cb + cc;
    tf = fa + fb + fc;
    if (!(da === 1'b1 && db === 1'b1 && dc === 1'b1)) begin
      tc++; tf++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", 0, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", tc, tf);
    $finish;
  end
endmodule